// File: doc/BRIEF.md
# Mesh Transposition Router for GF(2) Matrix-Vector Products

This block computes one sparse matrix-by-vector product over GF(2) on a small square mesh of cells. The mesh side is `M`, split into square blocks of side `B`. Each block stands for one matrix column and one vector element. Every cell stores at most one nonzero entry, given as the index of the matrix row it belongs to. The top-left cell of each block is that block's target cell and holds the result bit for the matching row.

Software loads the entries through a serial shift port. A start pulse then carries the input vector into the block. Each block's vector bit reaches every cell of that block. Every cell whose entry sees a 1 creates one packet addressed to the target cell of its row. The packets move between neighbouring cells by compare-exchange, one phase per clock. Two packets that meet with the same destination cancel each other. A packet that reaches its target is absorbed and flips that target's parity bit. When no packet is left, the parity bits form the product vector.

Top module: `mesh_rt_top`

## Requirements
- R1: After reset, `busy`, `done`, `limit_hit` and `res` are 0 and every cell is empty. A run started before any load finishes with `done` one clock after the start edge and `res` = 0.
- R2: Each clock with `ld_en` high while idle shifts the entry chain by one cell. Cell 0 takes {`ld_vld`, `ld_row`} and cell k takes the old content of cell k-1. Cell (x, y) has index y*M+x, so after N = M*M loads the first word loaded sits in cell N-1.
- R3: A start accepted while idle samples `vec_in` and clears all parity bits. Cell (x, y) belongs to block (y/B)*(M/B)+x/B, and `vec_in` bit j is the value for block j. Every valid entry in a block whose bit is 1 emits one packet. The packet goes to the top-left cell of the block numbered by the entry's row index. No other cell emits a packet.
- R4: When `done` rises without `limit_hit`, `res[i]` is the XOR, over all valid entries with row index i, of the vector bit of the block holding the entry. `res` holds its value until the next accepted start.
- R5: The clock after the start edge runs phase 0, and phases repeat with period 4. The phases are, in order: 0 horizontal pairs (x, x+1) with x odd, 1 vertical pairs (y, y+1) with y odd, 2 horizontal pairs with x even, 3 vertical pairs with y even. A lone packet in an active pair moves one cell towards its target along that axis.
- R6: A cell holds at most one packet. If both cells of an active pair hold packets for the same target, both packets vanish. Otherwise the packet whose target lies farther along the current axis takes the cell on its side, so the pair ends up ordered by target coordinate.
- R7: In each routing clock, packets already at their own target are absorbed before the exchange. Each absorption flips that target's `res` bit. Absorption and annihilation may happen in the same clock.
- R8: `busy` is 1 from the accepted start edge until the edge where `done` is set. `done` is a single-cycle pulse, raised on the clock where no packet remains after that clock's absorption and exchange.
- R9: If packets remain after `LIMIT_ROUNDS` full four-phase rounds (default 4*M), the block raises `done` together with `limit_hit`. `limit_hit` is 0 after a normal finish.
- R10: `start` and `ld_en` have no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Shift one entry into the chain |
| ld_vld | input | 1 | Entry valid flag for the shifted word |
| ld_row | input | IW | Row index of the shifted entry |
| start | input | 1 | Begin a product with `vec_in` |
| vec_in | input | D | Input vector, one bit per block |
| busy | output | 1 | Routing in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| limit_hit | output | 1 | Run ended on the round limit |
| res | output | D | Product vector, parity per target |

## Verification
The two mechanisms that remove packets, absorption at a target and pairwise annihilation of two packets bound for the same target, can act in the same clock. The bench provokes this with three entries. One entry's row is its own block, so its packet starts on its own target. The other two sit side by side in the first odd horizontal pair and share a distant destination. The bench expects `done` exactly one clock after the start edge, with only the self-addressed bit set in `res`. Throughout the run, the packet count is checked to drop by exactly the number absorbed plus the number annihilated.

// File: rtl/mesh_rt_pkg.sv
package mesh_rt_pkg;

  typedef enum logic [1:0] {
    PH_H_ODD = 2'd0,
    PH_V_ODD = 2'd1,
    PH_H_EVN = 2'd2,
    PH_V_EVN = 2'd3
  } phase_e;

  // block number of the cell at column x, row y
  function automatic int blk_of(int x, int y, int b, int nbx);
    return (y / b) * nbx + (x / b);
  endfunction

  // column of the target cell that serves row index dst
  function automatic int tgt_col(int dst, int b, int nbx);
    return (dst % nbx) * b;
  endfunction

  // row of the target cell that serves row index dst
  function automatic int tgt_row(int dst, int b, int nbx);
    return (dst / nbx) * b;
  endfunction

  // Pair decision along one axis. Slot a sits at coordinate pos, slot b at pos+1.
  // A lone packet moves towards its target. With two packets, the farther-going
  // one wins its side; for both directions this reduces to "larger target goes high".
  function automatic logic cex_swap(logic va, int ta, logic vb, int tb, int pos);
    if (va && vb) return ta >= tb;
    if (va)       return ta > pos;
    if (vb)       return tb <= pos;
    return 1'b0;
  endfunction

endpackage

// File: rtl/mesh_rt_chain.sv
module mesh_rt_chain #(
  parameter int N  = 16,
  parameter int IW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            in_vld,
  input  logic [IW-1:0]   in_row,
  output logic [N-1:0]    ent_v,
  output logic [N*IW-1:0] ent_r
);

  for (genvar c = 0; c < N; c++) begin : g_cell
    logic          src_v;
    logic [IW-1:0] src_r;
    logic          cv;
    logic [IW-1:0] cr;

    if (c == 0) begin : g_head
      assign src_v = in_vld;
      assign src_r = in_row;
    end else begin : g_link
      assign src_v = ent_v[c-1];
      assign src_r = ent_r[(c-1)*IW +: IW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cv <= 1'b0;
        cr <= '0;
      end else if (shift_en) begin
        cv <= src_v;
        cr <= src_r;
      end
    end

    assign ent_v[c]            = cv;
    assign ent_r[c*IW +: IW]   = cr;
  end

endmodule

// File: rtl/mesh_rt_cex.sv
module mesh_rt_cex
  import mesh_rt_pkg::*;
#(
  parameter int IW  = 2,
  parameter int CW  = 2,
  parameter int POS = 0
) (
  input  logic          va,
  input  logic [IW-1:0] da,
  input  logic [CW-1:0] ta,
  input  logic          vb,
  input  logic [IW-1:0] db,
  input  logic [CW-1:0] tb,
  output logic          swap,
  output logic          kill
);

  always_comb begin
    kill = va && vb && (da == db);
    swap = cex_swap(va, int'(ta), vb, int'(tb), POS);
  end

endmodule

// File: rtl/mesh_rt_seq.sv
module mesh_rt_seq
  import mesh_rt_pkg::*;
#(
  parameter int LIMIT_ROUNDS = 16,
  localparam int RW = (LIMIT_ROUNDS > 1) ? $clog2(LIMIT_ROUNDS) : 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go,
  input  logic   more,
  output logic   busy,
  output logic   done,
  output logic   limit_hit,
  output phase_e phase
);

  logic [RW-1:0] round;
  logic          last_phase;

  assign last_phase = (round == RW'(LIMIT_ROUNDS - 1)) && (phase == PH_V_EVN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      limit_hit <= 1'b0;
      phase     <= PH_H_ODD;
      round     <= '0;
    end else if (go) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      limit_hit <= 1'b0;
      phase     <= PH_H_ODD;
      round     <= '0;
    end else if (busy) begin
      if (!more) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (last_phase) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        limit_hit <= 1'b1;
      end else begin
        done  <= 1'b0;
        phase <= phase_e'(phase + 2'd1);
        if (phase == PH_V_EVN) round <= round + RW'(1);
      end
    end else begin
      done <= 1'b0;
    end
  end

endmodule

// File: rtl/mesh_rt_top.sv
module mesh_rt_top
  import mesh_rt_pkg::*;
#(
  parameter int M            = 4,
  parameter int B            = 2,
  parameter int LIMIT_ROUNDS = 4 * M,
  localparam int NBX = M / B,
  localparam int D   = NBX * NBX,
  localparam int N   = M * M,
  localparam int IW  = (D > 1) ? $clog2(D) : 1,
  localparam int CW  = (M > 1) ? $clog2(M) : 1,
  localparam int NP  = M * (M - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          ld_vld,
  input  logic [IW-1:0] ld_row,
  input  logic          start,
  input  logic [D-1:0]  vec_in,
  output logic          busy,
  output logic          done,
  output logic          limit_hit,
  output logic [D-1:0]  res
);

  // entry storage
  logic [N-1:0]    ent_v;
  logic [N*IW-1:0] ent_r;

  // packet state and its next value
  logic [N-1:0]  pk_v;
  logic [IW-1:0] pk_d [N];
  logic [N-1:0]  nx_v;
  logic [IW-1:0] nx_d [N];

  // named events, visible to the checker
  logic [N-1:0]  hit;     // packet absorbed at its target this clock
  logic [N-1:0]  ann;     // packet annihilated this clock
  logic [N-1:0]  s1_v;    // packets left after absorption
  logic [N-1:0]  em_v;    // packets created by a start
  logic [D-1:0]  acc_nx;
  logic          go;
  logic          more;
  phase_e        phase;
  logic          ph_vert;
  logic          ph_odd;

  logic [CW-1:0] tcol [N];
  logic [CW-1:0] trow [N];
  logic [NP-1:0] h_swap, h_kill, v_swap, v_kill;

  assign go      = start && !busy;
  assign ph_vert = (phase == PH_V_ODD) || (phase == PH_V_EVN);
  assign ph_odd  = (phase == PH_H_ODD) || (phase == PH_V_ODD);
  assign more    = |nx_v;

  mesh_rt_chain #(.N(N), .IW(IW)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (ld_en && !busy),
    .in_vld   (ld_vld),
    .in_row   (ld_row),
    .ent_v    (ent_v),
    .ent_r    (ent_r)
  );

  mesh_rt_seq #(.LIMIT_ROUNDS(LIMIT_ROUNDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .more      (more),
    .busy      (busy),
    .done      (done),
    .limit_hit (limit_hit),
    .phase     (phase)
  );

  // per-cell static decode: block, target flag, emission, absorption
  for (genvar c = 0; c < N; c++) begin : g_cell
    localparam int  CX   = c % M;
    localparam int  CY   = c / M;
    localparam int  OWN  = blk_of(CX, CY, B, NBX);
    localparam bit  IS_T = ((CX % B) == 0) && ((CY % B) == 0);

    assign em_v[c] = ent_v[c] && vec_in[OWN];
    assign hit[c]  = pk_v[c] && IS_T && (pk_d[c] == IW'(OWN));
    assign s1_v[c] = pk_v[c] && !hit[c];
    assign tcol[c] = CW'(tgt_col(int'(pk_d[c]), B, NBX));
    assign trow[c] = CW'(tgt_row(int'(pk_d[c]), B, NBX));
  end

  // parity accumulators, one per target cell
  for (genvar b = 0; b < D; b++) begin : g_acc
    localparam int TC = (b / NBX) * B * M + (b % NBX) * B;
    assign acc_nx[b] = res[b] ^ hit[TC];
  end

  // horizontal pairs: (x, y) with (x+1, y)
  for (genvar y = 0; y < M; y++) begin : g_hrow
    for (genvar x = 0; x < M - 1; x++) begin : g_hpair
      mesh_rt_cex #(.IW(IW), .CW(CW), .POS(x)) u_cex (
        .va   (s1_v[y*M+x]),
        .da   (pk_d[y*M+x]),
        .ta   (tcol[y*M+x]),
        .vb   (s1_v[y*M+x+1]),
        .db   (pk_d[y*M+x+1]),
        .tb   (tcol[y*M+x+1]),
        .swap (h_swap[y*(M-1)+x]),
        .kill (h_kill[y*(M-1)+x])
      );
    end
  end

  // vertical pairs: (x, y) with (x, y+1)
  for (genvar x = 0; x < M; x++) begin : g_vcol
    for (genvar y = 0; y < M - 1; y++) begin : g_vpair
      mesh_rt_cex #(.IW(IW), .CW(CW), .POS(y)) u_cex (
        .va   (s1_v[y*M+x]),
        .da   (pk_d[y*M+x]),
        .ta   (trow[y*M+x]),
        .vb   (s1_v[(y+1)*M+x]),
        .db   (pk_d[(y+1)*M+x]),
        .tb   (trow[(y+1)*M+x]),
        .swap (v_swap[x*(M-1)+y]),
        .kill (v_kill[x*(M-1)+y])
      );
    end
  end

  // apply the active phase's pair decisions
  always_comb begin
    nx_v = s1_v;
    ann  = '0;
    for (int c = 0; c < N; c++) nx_d[c] = pk_d[c];

    for (int y = 0; y < M; y++) begin
      for (int x = 0; x < M - 1; x++) begin
        if (!ph_vert && (((x % 2) == 1) == ph_odd)) begin
          if (h_kill[y*(M-1)+x]) begin
            ann[y*M+x]   = 1'b1;
            ann[y*M+x+1] = 1'b1;
          end else if (h_swap[y*(M-1)+x]) begin
            nx_v[y*M+x]   = s1_v[y*M+x+1];
            nx_v[y*M+x+1] = s1_v[y*M+x];
            nx_d[y*M+x]   = pk_d[y*M+x+1];
            nx_d[y*M+x+1] = pk_d[y*M+x];
          end
        end
      end
    end

    for (int x = 0; x < M; x++) begin
      for (int y = 0; y < M - 1; y++) begin
        if (ph_vert && (((y % 2) == 1) == ph_odd)) begin
          if (v_kill[x*(M-1)+y]) begin
            ann[y*M+x]     = 1'b1;
            ann[(y+1)*M+x] = 1'b1;
          end else if (v_swap[x*(M-1)+y]) begin
            nx_v[y*M+x]     = s1_v[(y+1)*M+x];
            nx_v[(y+1)*M+x] = s1_v[y*M+x];
            nx_d[y*M+x]     = pk_d[(y+1)*M+x];
            nx_d[(y+1)*M+x] = pk_d[y*M+x];
          end
        end
      end
    end

    nx_v = nx_v & ~ann;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk_v <= '0;
      res  <= '0;
      for (int c = 0; c < N; c++) pk_d[c] <= '0;
    end else if (go) begin
      pk_v <= em_v;
      res  <= '0;
      for (int c = 0; c < N; c++) pk_d[c] <= ent_r[c*IW +: IW];
    end else if (busy) begin
      pk_v <= nx_v;
      res  <= acc_nx;
      for (int c = 0; c < N; c++) pk_d[c] <= nx_d[c];
    end
  end

endmodule

// File: rtl/mesh_rt_chk.sv
module mesh_rt_chk #(
  parameter int N  = 16,
  parameter int D  = 4,
  parameter int IW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            ld_en,
  input logic            busy,
  input logic            done,
  input logic            limit_hit,
  input logic [D-1:0]    res,
  input logic [N-1:0]    pk_v,
  input logic [N-1:0]    hit,
  input logic [N-1:0]    ann,
  input logic [N-1:0]    ent_v,
  input logic [N*IW-1:0] ent_r
);

  // R6 / R7: packets leave only by absorption or pairwise annihilation
  assert_conserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (($countones(pk_v) + $past($countones(hit)) + $past($countones(ann)))
              == $past($countones(pk_v))));

  assert_clean_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !limit_hit) |-> (pk_v == '0));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_load_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld_en) |=> ($stable(ent_v) && $stable(ent_r)));

  assert_res_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(res));

  assert_limit_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(limit_hit) |-> done);

endmodule

bind mesh_rt_top mesh_rt_chk #(.N(N), .D(D), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ld_en     (ld_en),
  .busy      (busy),
  .done      (done),
  .limit_hit (limit_hit),
  .res       (res),
  .pk_v      (pk_v),
  .hit       (hit),
  .ann       (ann),
  .ent_v     (ent_v),
  .ent_r     (ent_r)
);

// File: tb/mesh_rt_top_tb.sv
module mesh_rt_top_tb;

  localparam int M = 4;
  localparam int N = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_en = 1'b0;
  logic       ld_vld = 1'b0;
  logic [1:0] ld_row = '0;
  logic       start = 1'b0;
  logic [3:0] vec_in = '0;

  logic       busy, done, limit_hit;
  logic [3:0] res;
  logic       busy_l, done_l, hit_l;
  logic [3:0] res_l;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  logic mv [N];
  int   mr [N];
  int unsigned seed = 32'h2468ace1;

  always #10 clk = ~clk;

  mesh_rt_top #(.M(4), .B(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_vld(ld_vld), .ld_row(ld_row),
    .start(start), .vec_in(vec_in), .busy(busy), .done(done),
    .limit_hit(limit_hit), .res(res)
  );

  mesh_rt_top #(.M(4), .B(2), .LIMIT_ROUNDS(1)) u_dut_lim (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_vld(ld_vld), .ld_row(ld_row),
    .start(start), .vec_in(vec_in), .busy(busy_l), .done(done_l),
    .limit_hit(hit_l), .res(res_l)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      total++;
      $display("FAIL watchdog R8 act=%0d exp=%0d", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // block of cell c: two blocks per band of two rows
  function automatic int blk(int c);
    return 2 * ((c / 4) / 2) + ((c % 4) / 2);
  endfunction

  function automatic logic [3:0] gf2(input logic [3:0] v);
    logic [3:0] r = '0;
    for (int c = 0; c < N; c++)
      if (mv[c] && v[blk(c)]) r[mr[c]] = ~r[mr[c]];
    return r;
  endfunction

  // clocks from start edge to done for a single packet, walking the phase schedule
  function automatic int path_lat(int x0, int y0, int tx, int ty);
    int x = x0;
    int y = y0;
    for (int k = 1; k <= 64; k++) begin
      int ph;
      int par;
      if (x == tx && y == ty) return k;
      ph  = (k - 1) % 4;
      par = (ph < 2) ? 1 : 0;
      if (ph == 0 || ph == 2) begin
        if (tx > x && (x % 2) == par && x + 1 < M) x++;
        else if (tx < x && ((x - 1) % 2) == par) x--;
      end else begin
        if (ty > y && (y % 2) == par && y + 1 < M) y++;
        else if (ty < y && ((y - 1) % 2) == par) y--;
      end
    end
    return 65;
  endfunction

  task automatic load_all();
    for (int k = N - 1; k >= 0; k--) begin
      @(negedge clk);
      ld_en  = 1'b1;
      ld_vld = mv[k];
      ld_row = 2'(mr[k]);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run(input logic [3:0] v, output int lat, output logic [3:0] r,
                     output int llat, output logic lhit, output logic b0);
    @(negedge clk);
    start  = 1'b1;
    vec_in = v;
    @(posedge clk);
    #1;
    start = 1'b0;
    b0    = busy;
    lat   = 0;
    llat  = 0;
    lhit  = 1'b0;
    for (int k = 1; k <= 200; k++) begin
      @(posedge clk);
      #1;
      if (done_l && llat == 0) begin
        llat = k;
        lhit = hit_l;
      end
      if (done) begin
        lat = k;
        break;
      end
    end
    r = res;
  endtask

  task automatic clear_mat();
    for (int c = 0; c < N; c++) begin
      mv[c] = 1'b0;
      mr[c] = 0;
    end
  endtask

  task automatic rand_mat();
    for (int c = 0; c < N; c++) begin
      seed  = seed * 32'd1103515245 + 32'd12345;
      mv[c] = ((seed >> 17) & 3) != 0;
      mr[c] = int'((seed >> 20) & 3);
    end
  endtask

  initial begin
    int lat, llat, k;
    logic [3:0] r;
    logic lhit, b0, got;

    clear_mat();
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && limit_hit == 0, "R1 reset flags", int'({busy, done, limit_hit}), 0);
    chk(res == 0, "R1 reset res", int'(res), 0);
    rst_n = 1'b1;

    // R1: empty mesh finishes one clock after start
    run(4'hF, lat, r, llat, lhit, b0);
    chk(lat == 1, "R1 empty latency", lat, 1);
    chk(r == 0, "R1 empty res", int'(r), 0);

    // R2 R3 R5 R7: one entry in every cell, addressed to every row
    for (int c = 0; c < N; c++) begin
      for (int rr = 0; rr < 4; rr++) begin
        int exp_lat;
        clear_mat();
        mv[c] = 1'b1;
        mr[c] = rr;
        load_all();
        exp_lat = path_lat(c % 4, c / 4, (rr % 2) * 2, (rr / 2) * 2);
        run(4'hF, lat, r, llat, lhit, b0);
        chk(lat == exp_lat, "R5 single packet latency", lat, exp_lat);
        chk(r == (4'b1 << rr), "R2 R3 R7 single entry result", int'(r), 1 << rr);
        chk(b0 == 1'b1, "R8 busy after start", int'(b0), 1);
        run(4'hF & ~(4'b1 << blk(c)), lat, r, llat, lhit, b0);
        chk(lat == 1 && r == 0, "R3 block bit clear emits nothing", lat * 16 + int'(r), 16);
      end
    end

    // R6 R7: absorption at a target plus an annihilating pair in the same clock
    clear_mat();
    mv[0] = 1'b1; mr[0] = 0;  // starts on its own target
    mv[1] = 1'b1; mr[1] = 3;  // pair (1,0)/(2,0), same destination
    mv[2] = 1'b1; mr[2] = 3;
    load_all();
    run(4'hF, lat, r, llat, lhit, b0);
    chk(lat == 1, "R6 R7 same-clock absorb and annihilate latency", lat, 1);
    chk(r == 4'b0001, "R6 R7 same-clock result", int'(r), 1);

    // R9: far packet on a one-round limit, normal finish on the default limit
    clear_mat();
    mv[15] = 1'b1; mr[15] = 0;
    load_all();
    run(4'hF, lat, r, llat, lhit, b0);
    chk(llat == 4 && lhit == 1'b1, "R9 limit reached after one round", llat * 2 + int'(lhit), 9);
    chk(lat == path_lat(3, 3, 0, 0), "R9 default limit not reached", lat, path_lat(3, 3, 0, 0));
    chk(limit_hit == 1'b0 && r == 4'b0001, "R9 normal finish flag", int'({limit_hit, r}), 1);

    // R4 R8: random matrices, every input vector
    for (int m = 0; m < 6; m++) begin
      rand_mat();
      load_all();
      for (int v = 0; v < 16; v++) begin
        run(4'(v), lat, r, llat, lhit, b0);
        chk(lat > 0 && r == gf2(4'(v)), "R4 product", int'(r), int'(gf2(4'(v))));
        chk(limit_hit == 1'b0, "R9 no limit on random case", int'(limit_hit), 0);
        @(posedge clk);
        #1;
        chk(done == 1'b0 && busy == 1'b0, "R8 done is one pulse", int'({done, busy}), 0);
        chk(res == gf2(4'(v)), "R4 result held", int'(res), int'(gf2(4'(v))));
      end
    end

    // R10: load and start while busy are ignored
    rand_mat();
    load_all();
    @(negedge clk);
    start  = 1'b1;
    vec_in = 4'hF;
    @(posedge clk);
    #1;
    start = 1'b0;
    @(negedge clk);
    start  = 1'b1;
    vec_in = 4'h5;
    ld_en  = 1'b1;
    ld_vld = 1'b1;
    ld_row = 2'd2;
    @(posedge clk);
    #1;
    start = 1'b0;
    ld_en = 1'b0;
    k   = 1;
    got = done;
    while (!got && k < 200) begin
      @(posedge clk);
      #1;
      k++;
      got = done;
    end
    chk(got == 1'b1 && res == gf2(4'hF), "R10 start ignored while busy", int'(res), int'(gf2(4'hF)));
    run(4'h5, lat, r, llat, lhit, b0);
    chk(r == gf2(4'h5), "R10 load ignored while busy", int'(r), int'(gf2(4'h5)));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule